// File: doc/BRIEF.md
# Inhibit-Handshake Angle Read Sequencer

This block sits on the host side of a tracking angle converter and reads its 16-bit angle word safely. The converter's counter updates in single-count steps, and each update comes with a busy pulse. The counter only freezes once an inhibit line is held high. A read request makes the sequencer raise inhibit and wait until the converter's busy line has dropped. It then counts a fixed number of settling clocks and captures the angle word. Finally it releases inhibit and presents the captured word with a one-cycle valid strobe.

The busy line is asynchronous to the host clock and passes through a two-flop synchroniser. A busy interval that is already running when inhibit goes up delays the settling count until that interval is over. If busy reappears during the settling count, the count starts again. If busy stays high longer than a configurable limit, the read is abandoned: inhibit is released, no valid strobe is produced, and an error flag is raised. The flag stays high until the next read begins. A request that arrives while a read is in flight is remembered and served once the current read finishes. Any number of such requests merge into one follow-up read.

Top module: `angle_rd_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, inhibitOut, wordValid and errFlag are 0 and wordOut is all zeros.
- R2: Suppose a request is sampled while the sequencer is idle. Then inhibitOut is 1 from the next cycle on and stays 1 continuously until the cycle in which wordValid or errFlag rises. In that cycle inhibitOut is 0.
- R3: With busyIn held low, wordValid is 1 in the cycle that follows the (SETTLE_CYC+3)-th rising edge after the edge that sampled the request.
- R4: Suppose busyIn is already high when the request is sampled and falls before the timeout. Then wordValid rises after the edge that lies SETTLE_CYC+4 edges past the last edge that sampled busyIn high.
- R5: If busyIn is sampled high during the settling count, the count restarts. wordValid rises after the edge that lies SETTLE_CYC+3 edges past that busy sample.
- R6: wordValid is high for exactly one cycle. In that cycle wordOut equals the angleIn value present while inhibit was high.
- R7: If busy is seen high on the synchronised line for TIMEOUT_CYC consecutive wait cycles, the read is abandoned. errFlag rises and inhibitOut falls on the (TIMEOUT_CYC+1)-th edge after the request edge. No valid strobe is produced and wordOut keeps its previous value.
- R8: errFlag returns to 0 in the same cycle that inhibitOut rises for the next read.
- R9: A request sampled during a read is served afterwards. inhibitOut is 0 in the cycle after the valid cycle and is 1 in the cycle after that. The follow-up valid comes SETTLE_CYC+5 edges after the first valid edge.
- R10: Several requests sampled during one read produce exactly one follow-up read. After it, inhibitOut stays 0 with no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset |
| readReq | input | 1 | Read request, one cycle or longer |
| busyIn | input | 1 | Converter busy, asynchronous |
| angleIn | input | ANGLE_W | Angle word from the converter |
| inhibitOut | output | 1 | Inhibit to the converter, high freezes its counter |
| wordOut | output | ANGLE_W | Last captured angle word |
| wordValid | output | 1 | One-cycle strobe, wordOut freshly captured |
| errFlag | output | 1 | Busy timeout on the last read |

## Verification
The hardest situation to reach from the ports is a busy pulse that lands inside the settling count, after the wait for busy to clear has already finished. Producing it needs a busy pulse placed a known number of edges after the request, with the two synchroniser stages taken into account. The bench times that pulse so that the synchronised copy arrives mid-count, then checks the restarted latency exactly. Random busy lengths on both sides of the timeout limit cover the exact boundary between a late but valid read and an abandoned one.

// File: rtl/angle_rd_pkg.sv
package angle_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASSERT_INH,
    ST_WAIT_BUSY_LOW,
    ST_SETTLE,
    ST_CAPTURE,
    ST_RELEASE
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSettle;
    logic incSettle;
    logic clrTmo;
    logic incTmo;
    logic capture;
    logic setErr;
    logic clrErr;
  } rdStrobe_t;

endpackage

// File: rtl/angle_rd_sync.sv
module angle_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] stageQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[0] <= 1'b0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[i] <= 1'b0;
          else       stageQ[i] <= stageQ[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/angle_rd_ctrl.sv
module angle_rd_ctrl
  import angle_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      readReq,
  input  logic      busySync,
  input  logic      settleDone,
  input  logic      tmoDone,
  output rdStrobe_t stb,
  output logic      inhibitOut
);

  rdState_t stateQ, stateD;
  logic     pendQ, pendD;
  logic     startRd;

  assign startRd = (stateQ == ST_IDLE) && (readReq || pendQ);

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startRd) begin
          stb.clrErr = 1'b1;
          stateD     = ST_ASSERT_INH;
        end
      end
      ST_ASSERT_INH: begin
        stb.clrTmo = 1'b1;
        stateD     = ST_WAIT_BUSY_LOW;
      end
      ST_WAIT_BUSY_LOW: begin
        if (!busySync) begin
          stb.clrSettle = 1'b1;
          stateD        = ST_SETTLE;
        end else if (tmoDone) begin
          stb.setErr = 1'b1;
          stateD     = ST_RELEASE;
        end else begin
          stb.incTmo = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (busySync)        stb.clrSettle = 1'b1;
        else if (settleDone) stateD        = ST_CAPTURE;
        else                 stb.incSettle = 1'b1;
      end
      ST_CAPTURE: begin
        stb.capture = 1'b1;
        stateD      = ST_RELEASE;
      end
      ST_RELEASE: stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  // requests seen during a read merge into one pending follow-up
  assign pendD = (pendQ || readReq) && !startRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
    end
  end

  assign inhibitOut = (stateQ == ST_ASSERT_INH) || (stateQ == ST_WAIT_BUSY_LOW) ||
                      (stateQ == ST_SETTLE)     || (stateQ == ST_CAPTURE);

  // R9
  pend_served_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RELEASE && pendQ) |=> ##1 (stateQ == ST_ASSERT_INH));

  // R5
  settle_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CAPTURE) |-> ($past(stateQ) == ST_SETTLE && !$past(busySync)));

endmodule

// File: rtl/angle_rd_dp.sv
module angle_rd_dp
  import angle_rd_pkg::*;
#(
  parameter int ANGLE_W     = 16,
  parameter int SETTLE_CYC  = 24,
  parameter int TIMEOUT_CYC = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busyIn,
  input  logic [ANGLE_W-1:0] angleIn,
  input  rdStrobe_t          stb,
  output logic               busySync,
  output logic               settleDone,
  output logic               tmoDone,
  output logic [ANGLE_W-1:0] wordOut,
  output logic               wordValid,
  output logic               errFlag
);

  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] TMO_LAST    = TW'(TIMEOUT_CYC - 1);

  logic [SW-1:0] settleCnt;
  logic [TW-1:0] tmoCnt;

  angle_rd_sync #(.STAGES(SYNC_STAGES)) busySync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (busyIn),
    .syncOut (busySync)
  );

  always_ff @(posedge clk) begin
    if (!rstN)              settleCnt <= '0;
    else if (stb.clrSettle) settleCnt <= '0;
    else if (stb.incSettle) settleCnt <= settleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           tmoCnt <= '0;
    else if (stb.clrTmo) tmoCnt <= '0;
    else if (stb.incTmo) tmoCnt <= tmoCnt + 1'b1;
  end

  assign settleDone = (settleCnt == SETTLE_LAST);
  assign tmoDone    = (tmoCnt == TMO_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      wordValid <= stb.capture;
      if (stb.capture) wordOut <= angleIn;
      if (stb.clrErr)      errFlag <= 1'b0;
      else if (stb.setErr) errFlag <= 1'b1;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R6
  word_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordOut == $past(angleIn)));

  // R3
  capture_settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> $past(settleDone));

  // R7
  err_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (!wordValid && $stable(wordOut)));

endmodule

// File: rtl/angle_rd_seq.sv
module angle_rd_seq
  import angle_rd_pkg::*;
#(
  parameter int ANGLE_W     = 16,
  parameter int SETTLE_CYC  = 24,
  parameter int TIMEOUT_CYC = 400
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               readReq,
  input  logic               busyIn,
  input  logic [ANGLE_W-1:0] angleIn,
  output logic               inhibitOut,
  output logic [ANGLE_W-1:0] wordOut,
  output logic               wordValid,
  output logic               errFlag
);

  rdStrobe_t stb;
  logic      busySync;
  logic      settleDone;
  logic      tmoDone;

  angle_rd_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .readReq    (readReq),
    .busySync   (busySync),
    .settleDone (settleDone),
    .tmoDone    (tmoDone),
    .stb        (stb),
    .inhibitOut (inhibitOut)
  );

  angle_rd_dp #(
    .ANGLE_W     (ANGLE_W),
    .SETTLE_CYC  (SETTLE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .SYNC_STAGES (2)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .busyIn     (busyIn),
    .angleIn    (angleIn),
    .stb        (stb),
    .busySync   (busySync),
    .settleDone (settleDone),
    .tmoDone    (tmoDone),
    .wordOut    (wordOut),
    .wordValid  (wordValid),
    .errFlag    (errFlag)
  );

  // R2
  inhibit_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inhibitOut) |-> (wordValid || errFlag));

  // R8
  err_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inhibitOut) |-> !errFlag);

endmodule

// File: tb/angle_rd_seq_tb_top.sv
module angle_rd_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int NSET = 24;
  localparam int NTMO = 400;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          readReq = 1'b0;
  logic          busyIn = 1'b0;
  logic [AW-1:0] angleIn = '0;
  logic          inhibitOut, wordValid, errFlag;
  logic [AW-1:0] wordOut;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 1'b0;
  logic [AW-1:0] lastWord = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  angle_rd_seq #(.ANGLE_W(AW), .SETTLE_CYC(NSET), .TIMEOUT_CYC(NTMO)) dut_i (
    .clk(clk), .rstN(rstN), .readReq(readReq), .busyIn(busyIn), .angleIn(angleIn),
    .inhibitOut(inhibitOut), .wordOut(wordOut), .wordValid(wordValid), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected edge count (from the edge before the request edge) to the result
  function automatic int expEdges(input int busyLen, input int pulseAt);
    if (busyLen >= NTMO) return NTMO + 2;
    if (busyLen > 0)     return busyLen + NSET + 4;
    if (pulseAt > 0)     return pulseAt + NSET + 3;
    return NSET + 4;
  endfunction

  task automatic runRead(input int busyLen, input int pulseAt, input int reqA, input int reqB,
                         input string tag);
    int c;
    int gotC;
    bit inhOk;
    logic [AW-1:0] heldAngle;
    heldAngle = AW'($urandom);
    @(posedge clk); #1;
    angleIn = heldAngle;
    readReq = 1'b1;
    busyIn  = (busyLen > 0);
    c = 0; gotC = 0; inhOk = 1'b1;
    while (gotC == 0 && c < NTMO + NSET + 40) begin
      @(posedge clk); c++; #1;
      readReq = (c == reqA) || (c == reqB);
      if (busyLen > 0 && c == busyLen) busyIn = 1'b0;
      if (pulseAt > 0 && c == pulseAt - 1) busyIn = 1'b1;
      if (pulseAt > 0 && c == pulseAt) busyIn = 1'b0;
      @(negedge clk);
      if (c == 1) check(errFlag == 1'b0, "R8", int'(errFlag), 0);
      if (wordValid || errFlag) gotC = c;
      else if (!inhibitOut) inhOk = 1'b0;
    end
    check(inhOk, "R2", int'(inhOk), 1);
    check(gotC == expEdges(busyLen, pulseAt), tag, gotC, expEdges(busyLen, pulseAt));
    check(inhibitOut == 1'b0, "R2", int'(inhibitOut), 0);
    if (busyLen >= NTMO) begin
      check(errFlag && !wordValid, "R7", int'({errFlag, wordValid}), 2);
      check(wordOut == lastWord, "R7", int'(wordOut), int'(lastWord));
    end else begin
      check(wordValid && !errFlag, tag, int'({wordValid, errFlag}), 2);
      check(wordOut == heldAngle, "R6", int'(wordOut), int'(heldAngle));
      lastWord = heldAngle;
    end
  endtask

  // follow-up read from a held request, counted from the valid cycle
  task automatic followRead();
    int k;
    bit seen;
    seen = 1'b0;
    for (k = 1; k <= NSET + 5 && !seen; k++) begin
      @(posedge clk); #1;
      angleIn = lastWord + 16'd7;
      @(negedge clk);
      if (k == 1) check(inhibitOut == 1'b0, "R9", int'(inhibitOut), 0);
      if (k == 2) check(inhibitOut == 1'b1, "R9", int'(inhibitOut), 1);
      if (wordValid) begin
        seen = 1'b1;
        check(k == NSET + 5, "R9", k, NSET + 5);
        check(wordOut == lastWord + 16'd7, "R9", int'(wordOut), int'(lastWord + 16'd7));
        lastWord = wordOut;
      end
    end
    check(seen, "R9", int'(seen), 1);
  endtask

  task automatic idleCycles(input int n, input string tag, input bit checkQuiet);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      angleIn = AW'($urandom);
      @(negedge clk);
      if (checkQuiet && (inhibitOut || wordValid)) begin
        check(1'b0, tag, int'({inhibitOut, wordValid}), 0);
        checkQuiet = 1'b0;
      end
    end
    if (checkQuiet) check(1'b1, tag, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!inhibitOut && !wordValid && !errFlag && wordOut == '0, "R1",
          int'({inhibitOut, wordValid, errFlag}), 0);
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    check(!inhibitOut && !wordValid && !errFlag && wordOut == '0, "R1",
          int'({inhibitOut, wordValid, errFlag}), 0);

    // directed corners
    runRead(0, 0, 0, 0, "R3");
    idleCycles(1, "R6", 1'b1);
    runRead(5, 0, 0, 0, "R4");
    runRead(NTMO - 1, 0, 0, 0, "R4");
    runRead(NTMO, 0, 0, 0, "R7");
    idleCycles(2, "R7", 1'b1);
    runRead(0, 0, 0, 0, "R8");
    runRead(0, 6, 0, 0, "R5");
    runRead(0, NSET, 0, 0, "R5");
    runRead(0, 0, 5, 0, "R3");
    followRead();
    idleCycles(2, "R9", 1'b0);
    runRead(0, 0, 3, 9, "R3");
    followRead();
    idleCycles(3 * NSET, "R10", 1'b1);

    // random busy lengths around the timeout limit
    for (int t = 0; t < 30; t++) begin
      int len;
      len = ($urandom % 2 == 0) ? int'($urandom % 60) : int'($urandom % (NTMO + 40));
      if (len >= NTMO) runRead(len, 0, 0, 0, "R7");
      else             runRead(len, 0, 0, 0, "R4");
      idleCycles(1 + int'($urandom % 4), "R6", 1'b1);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

endmodule